// File: doc/BRIEF.md
# Bus Idle and Transmit Permit Timer

This block watches a shared serial receive line and measures, in bit times, how long the line has stayed high. Once the high run reaches a programmable idle-wait length, the bus counts as idle. A node with a frame waiting is allowed to start sending only when the idle run reaches its own transmit-permit length. Each node on the bus is given a different permit length, so the nodes start at staggered points and do not collide.

Two scheduling modes are supported:

- **Arbitration mode** is the default. A pending frame gets its permit at the first cycle in which the idle run has reached the permit length.
- **Break-sync mode** takes precedence when it is enabled. A frame that was pending when the permit point arrived starts exactly at that point. A frame raised later waits until the idle run exceeds a maximum idle length. The block then asks the transmitter to send a break character, which pulls the bus out of idle.

Independently of the mode, a long low level on the line is reported as a received break. The bit period is supplied as a clock divisor by the surrounding controller. Byte framing and the transmit shifter are outside this block.

The interfaces are plain level and pulse signals; there is no data stream, so no valid/ready handshake applies.

Top module: `bus_idle_permit`

## Requirements
- R1: One bit time lasts `bit_div_i + 1` clock cycles. Bit timing restarts at every change of the sampled `rx_i` level.
- R2: `bus_idle_o` rises in the cycle after `rx_i` has been sampled high for `idle_wait_i * (bit_div_i + 1) + 1` consecutive edges. Any low sample of `rx_i` clears it at the next edge and restarts the count.
- R3: In arbitration mode (`arb_en_i`=1, `bsync_en_i`=0), `tx_permit_o` is a one-cycle pulse. It fires at the first edge where `frame_pending_i` is high and the idle run is at least `permit_len_i` bit times, and it fires at most once per idle period.
- R4: In break-sync mode (`bsync_en_i`=1, regardless of `arb_en_i`), `tx_permit_o` pulses only at the edge where the idle run first reaches exactly `permit_len_i` bit times, and only if `frame_pending_i` is high at that edge. A frame raised later gets no permit in that idle period.
- R5: In break-sync mode, `send_break_o` is a one-cycle pulse. It fires at the edge where the idle run first reaches `max_idle_i + 1` bit times, provided `frame_pending_i` is high and no permit was given in the current idle period.
- R6: `break_rx_o` is a one-cycle pulse when `rx_i` has stayed low for more than 10 bit times, that is, when the low run reaches 11 bit times.
- R7: The idle run saturates at 2047 bit times and never wraps. A long idle therefore produces no second permit or break request.
- R8: With both mode bits 0, `tx_permit_o` and `send_break_o` stay low. `bus_idle_o` and `break_rx_o` still work.
- R9: During and right after reset, all outputs are low, and the line is treated as having just been low, so idle must be proven anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, already synchronised |
| frame_pending_i | input | 1 | A frame is waiting to be sent |
| arb_en_i | input | 1 | Arbitration mode select |
| bsync_en_i | input | 1 | Break-sync mode select (wins over arbitration) |
| idle_wait_i | input | 8 | Idle-wait length in bit times |
| permit_len_i | input | 10 | Transmit-permit length in bit times |
| max_idle_i | input | 10 | Maximum idle length in bit times (break-sync) |
| bit_div_i | input | 16 | Clock cycles per bit, minus one |
| bus_idle_o | output | 1 | Bus is idle |
| tx_permit_o | output | 1 | One-cycle permission to start sending |
| send_break_o | output | 1 | One-cycle request to send a break character |
| break_rx_o | output | 1 | One-cycle pulse: break detected on the line |

## Verification
The hardest situations to reach are the ones that depend on when `frame_pending_i` arrives relative to the permit point in break-sync mode.

- A frame raised before that point must get a permit and must never lead to a break request.
- A frame raised after that point must get no permit and must lead to exactly one break request, at `max_idle_i + 1`.

The stimulus holds the line high across both points and raises the pending flag before, or after, the permit point. A separate run at a divisor of 0 holds the line high past 2047 bit times and toggles the pending flag, to show that saturation gives no second pulse. Break detection is probed on both sides of its threshold, with low runs of 10 and 11 bit times.

// File: rtl/bip_pkg.sv
package bip_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_ARB   = 2'd1,
    MODE_BSYNC = 2'd2
  } bip_mode_e;

  function automatic bip_mode_e decode_mode(input logic arb, input logic bsync);
    if (bsync)    return MODE_BSYNC;
    else if (arb) return MODE_ARB;
    else          return MODE_OFF;
  endfunction
endpackage

// File: rtl/bip_bit_timer.sv
module bip_bit_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             rx_q_o,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             chg;

  assign chg    = (rx_i != rx_q_o);
  assign tick_o = !chg && (cnt_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      rx_q_o <= rx_i;
      if (chg || tick_o) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bip_run_ctr.sv
module bip_run_ctr #(
  parameter int   W     = 11,
  parameter logic LEVEL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_i,
  input  logic         rx_q_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o
);
  always_comb begin
    if (rx_i != LEVEL || rx_q_i != LEVEL) nxt_o = '0;
    else if (tick_i && cnt_o != '1)       nxt_o = cnt_o + 1'b1;
    else                                  nxt_o = cnt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= nxt_o;
  end
endmodule

// File: rtl/bip_permit_ctrl.sv
module bip_permit_ctrl
  import bip_pkg::*;
#(
  parameter int LEN_W = 10,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bip_mode_e        mode_i,
  input  logic             rx_i,
  input  logic             rx_q_i,
  input  logic [CNT_W-1:0] idle_cnt_i,
  input  logic [CNT_W-1:0] idle_nxt_i,
  input  logic             pending_i,
  input  logic [LEN_W-1:0] permit_len_i,
  input  logic [LEN_W-1:0] max_idle_i,
  output logic             permit_o,
  output logic             send_break_o
);
  logic [CNT_W-1:0] permit_pt, break_pt;
  logic             done_q;
  logic             at_permit, at_break;
  logic             fire_permit, fire_break;

  assign permit_pt = CNT_W'(permit_len_i);
  assign break_pt  = CNT_W'(max_idle_i) + 1'b1;

  // first edge at which the idle run equals a given point
  assign at_permit = rx_i && (idle_nxt_i == permit_pt) && !(rx_q_i && idle_cnt_i == permit_pt);
  assign at_break  = rx_i && (idle_nxt_i == break_pt)  && !(rx_q_i && idle_cnt_i == break_pt);

  always_comb begin
    fire_permit = 1'b0;
    fire_break  = 1'b0;
    unique case (mode_i)
      MODE_ARB:   fire_permit = rx_i && pending_i && !done_q && (idle_nxt_i >= permit_pt);
      MODE_BSYNC: begin
        fire_permit = pending_i && at_permit;
        fire_break  = pending_i && at_break && !done_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q       <= 1'b0;
      permit_o     <= 1'b0;
      send_break_o <= 1'b0;
    end else begin
      done_q       <= rx_i && (done_q || fire_permit || fire_break);
      permit_o     <= fire_permit;
      send_break_o <= fire_break;
    end
  end
endmodule

// File: rtl/bus_idle_permit.sv
module bus_idle_permit
  import bip_pkg::*;
#(
  parameter int WAIT_W   = 8,
  parameter int LEN_W    = 10,
  parameter int DIV_W    = 16,
  parameter int BRK_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              frame_pending_i,
  input  logic              arb_en_i,
  input  logic              bsync_en_i,
  input  logic [WAIT_W-1:0] idle_wait_i,
  input  logic [LEN_W-1:0]  permit_len_i,
  input  logic [LEN_W-1:0]  max_idle_i,
  input  logic [DIV_W-1:0]  bit_div_i,
  output logic              bus_idle_o,
  output logic              tx_permit_o,
  output logic              send_break_o,
  output logic              break_rx_o
);
  localparam int CNT_W = LEN_W + 1;
  localparam int LOW_W = $clog2(BRK_BITS + 2);
  localparam logic [LOW_W-1:0] BRK_AT = LOW_W'(BRK_BITS + 1);
  localparam logic [LOW_W-1:0] BRK_PRE = LOW_W'(BRK_BITS);

  logic             rx_q, tick;
  logic [CNT_W-1:0] idle_cnt, idle_nxt;
  logic [LOW_W-1:0] low_cnt, low_nxt;
  bip_mode_e        mode;

  assign mode = decode_mode(arb_en_i, bsync_en_i);

  bip_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .div_i(bit_div_i),
    .rx_q_o(rx_q), .tick_o(tick)
  );

  bip_run_ctr #(.W(CNT_W), .LEVEL(1'b1)) u_high (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .rx_q_i(rx_q), .tick_i(tick),
    .cnt_o(idle_cnt), .nxt_o(idle_nxt)
  );

  bip_run_ctr #(.W(LOW_W), .LEVEL(1'b0)) u_low (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .rx_q_i(rx_q), .tick_i(tick),
    .cnt_o(low_cnt), .nxt_o(low_nxt)
  );

  bip_permit_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .rx_i(rx_i), .rx_q_i(rx_q),
    .idle_cnt_i(idle_cnt), .idle_nxt_i(idle_nxt), .pending_i(frame_pending_i),
    .permit_len_i(permit_len_i), .max_idle_i(max_idle_i),
    .permit_o(tx_permit_o), .send_break_o(send_break_o)
  );

  assign bus_idle_o = rx_q && (idle_cnt >= CNT_W'(idle_wait_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) break_rx_o <= 1'b0;
    else        break_rx_o <= (low_nxt == BRK_AT) && (low_cnt == BRK_PRE);
  end
endmodule

// File: rtl/bip_checker.sv
module bip_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_i,
  input logic frame_pending_i,
  input logic arb_en_i,
  input logic bsync_en_i,
  input logic bus_idle_o,
  input logic tx_permit_o,
  input logic send_break_o,
  input logic break_rx_o
);
  p_idle_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_i |=> !bus_idle_o);
  p_permit_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit_o |=> !tx_permit_o);
  p_permit_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit_o |-> $past(frame_pending_i && rx_i));
  p_break_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    send_break_o |=> !send_break_o);
  p_break_req_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    send_break_o |-> $past(bsync_en_i && frame_pending_i));
  p_no_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit_o |-> $past(arb_en_i || bsync_en_i));
  p_break_rx_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    break_rx_o |-> (!bus_idle_o && $past(!rx_i)));
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_permit_o && send_break_o));
endmodule

bind bus_idle_permit bip_checker u_bip_checker (
  .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .frame_pending_i(frame_pending_i),
  .arb_en_i(arb_en_i), .bsync_en_i(bsync_en_i), .bus_idle_o(bus_idle_o),
  .tx_permit_o(tx_permit_o), .send_break_o(send_break_o), .break_rx_o(break_rx_o)
);

// File: tb/tb_bus_idle_permit.sv
`timescale 1ns/1ps
module tb_bus_idle_permit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b0, pend = 1'b0, arb = 1'b1, bs = 1'b0;
  logic [7:0]  wait_len = 8'd10;
  logic [9:0]  permit_len = 10'd20, max_idle = 10'd200;
  logic [15:0] div = 16'd3;
  logic        bus_idle, tx_permit, send_break, break_rx;

  int checks = 0, fails = 0, cycles = 0;
  int n_permit = 0, n_sbreak = 0, n_brk = 0, n_idle = 0;

  // reference model state
  int  hrun = 0, lrun = 0, m_idle = 0, m_low = 0, m_done = 0;
  bit  m_line = 0;
  bit  e_idle = 0, e_permit = 0, e_sbreak = 0, e_brk = 0;

  always #10 clk = ~clk;

  bus_idle_permit dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .frame_pending_i(pend),
    .arb_en_i(arb), .bsync_en_i(bs), .idle_wait_i(wait_len),
    .permit_len_i(permit_len), .max_idle_i(max_idle), .bit_div_i(div),
    .bus_idle_o(bus_idle), .tx_permit_o(tx_permit),
    .send_break_o(send_break), .break_rx_o(break_rx)
  );

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference, advanced on every edge from the bench's own inputs
  always @(posedge clk) begin
    int prev_idle, prev_low, per;
    bit prev_line;
    cycles++;
    if (!rst_n) begin
      hrun = 0; lrun = 0; m_idle = 0; m_low = 0; m_done = 0; m_line = 0;
      e_idle = 0; e_permit = 0; e_sbreak = 0; e_brk = 0;
    end else begin
      prev_idle = m_idle; prev_low = m_low; prev_line = m_line;
      per = int'(div) + 1;
      if (rx) begin hrun = imin(hrun + 1, 1000000); lrun = 0; end
      else    begin lrun = imin(lrun + 1, 1000000); hrun = 0; end
      m_idle = (hrun == 0) ? 0 : imin((hrun - 1) / per, 2047);
      m_low  = (lrun == 0) ? 0 : imin((lrun - 1) / per, 15);
      m_line = rx;
      e_permit = 0; e_sbreak = 0;
      if (rx && pend) begin
        if (bs) begin
          if (m_idle == int'(permit_len) && !(prev_line && prev_idle == int'(permit_len)))
            e_permit = 1;
          if (m_done == 0 && m_idle == int'(max_idle) + 1 &&
              !(prev_line && prev_idle == int'(max_idle) + 1))
            e_sbreak = 1;
        end else if (arb) begin
          if (m_done == 0 && m_idle >= int'(permit_len)) e_permit = 1;
        end
      end
      m_done = rx ? (m_done | e_permit | e_sbreak) : 0;
      e_brk  = (m_low == 11) && (prev_low == 10);
      e_idle = rx && (m_idle >= int'(wait_len));
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R9 bus_idle in reset", bus_idle, 0);
      chk("R9 tx_permit in reset", tx_permit, 0);
      chk("R9 break_rx in reset", break_rx, 0);
    end else begin
      chk("R2 bus_idle", bus_idle, e_idle);
      chk("R3/R4 tx_permit", tx_permit, e_permit);
      chk("R5 send_break", send_break, e_sbreak);
      chk("R6 break_rx", break_rx, e_brk);
      n_permit += tx_permit; n_sbreak += send_break; n_brk += break_rx; n_idle += bus_idle;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic clear_counts();
    n_permit = 0; n_sbreak = 0; n_brk = 0; n_idle = 0;
  endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(1);
    chk("R9 bus_idle right after reset", bus_idle, 0);

    // R3: arbitration, frame pending from the start
    clear_counts();
    pend = 1; rx = 1; cyc(200);
    rx = 0; cyc(3); rx = 1; cyc(120);
    chk("R3 permits over two idle periods", n_permit, 2);
    chk("R1 bus idle reached", (n_idle > 0) ? 1 : 0, 1);

    // R3: late pending gets an immediate permit
    clear_counts();
    pend = 0; rx = 0; cyc(3); rx = 1; cyc(160);
    pend = 1; cyc(20); pend = 0; cyc(5);
    chk("R3 late pending permit", n_permit, 1);

    // R4/R5: break-sync, early pending
    clear_counts();
    bs = 1; max_idle = 10'd30; pend = 1; rx = 0; cyc(3); rx = 1; cyc(200);
    chk("R4 early pending permit", n_permit, 1);
    chk("R5 no break request after permit", n_sbreak, 0);

    // R4/R5: break-sync, pending raised after the permit point
    clear_counts();
    pend = 0; rx = 0; cyc(3); rx = 1; cyc(100);
    pend = 1; cyc(60);
    chk("R4 late pending gets no permit", n_permit, 0);
    chk("R5 break request at max idle", n_sbreak, 1);
    pend = 0; bs = 0;

    // R6: break detection threshold
    clear_counts();
    rx = 0; cyc(44); rx = 1; cyc(10);
    chk("R6 ten low bits is no break", n_brk, 0);
    rx = 0; cyc(48); rx = 1; cyc(10);
    chk("R6 eleven low bits is a break", n_brk, 1);

    // R8: no mode selected
    clear_counts();
    arb = 0; pend = 1; rx = 0; cyc(3); rx = 1; cyc(200);
    chk("R8 no permit without mode", n_permit, 0);
    chk("R8 bus idle still works", (n_idle > 0) ? 1 : 0, 1);
    rx = 0; cyc(60); rx = 1; cyc(5);
    chk("R8 break still detected", n_brk, 1);
    arb = 1;

    // R7: saturation at divisor 0
    clear_counts();
    rx = 0; div = 16'd0; cyc(3); rx = 1; cyc(2200);
    for (int i = 0; i < 4; i++) begin pend = 0; cyc(7); pend = 1; cyc(7); end
    chk("R7 single permit over long idle", n_permit, 1);

    // R1/R2/R3: zero lengths, divisor 2
    clear_counts();
    pend = 1; wait_len = 0; permit_len = 0; rx = 0; div = 16'd2; cyc(3);
    rx = 1; cyc(1);
    chk("R2 idle at first high sample with zero wait", bus_idle, 1);
    chk("R3 permit at first high sample with zero length", tx_permit, 1);
    cyc(20);
    rx = 0; cyc(1);
    chk("R2 low sample clears idle", bus_idle, 0);
    cyc(5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule